// File: doc/BRIEF.md
# PWM Channel with Locked Update

A single-channel pulse-width modulator controlled through a small word-addressed register bus. Software programs a period and a duty count, both in input-clock cycles, and a control word that enables the channel and picks two output levels. The first is the level driven during the duty portion. The second is the level held while the channel is idle. A free-running counter steps from zero to period minus one. The output shows the duty level while the counter is below the duty count, and the opposite level for the rest of the period.

New period, duty and polarity values never reach the output partway through a period. They wait in staging copies and move into the active set only when the counter wraps. A lock bit in the control word holds that transfer back. Software can set the lock, rewrite several fields, then clear the lock, and the whole new configuration starts together at the next period start. Continuous left-aligned operation is the only waveform. The mode, alignment and low-power fields are stored and read back but do not change the output.

Top module: `pwm_lockchan`

## Requirements
- R1: After reset, all four registers read as zero and `pwm_out` is low.
- R2: While control bit 0 (enable) is 0, the counter reads zero and `pwm_out` holds the idle level given by control bit 4 (1 = high).
- R3: While enabled with a nonzero active period P, the counter register (offset 0x0) steps by one each clock from 0 to P-1 and then wraps to 0.
- R4: While enabled, `pwm_out` is at the duty level of control bit 3 (1 = high) while the counter is below the active duty D, and at the opposite level otherwise. D >= P gives the duty level for the whole period, and P = 0 gives the idle level.
- R5: While control bit 6 (lock) is 1, writes to period (offset 0x4) and duty (offset 0x8), and changes to control bits 3 and 4, leave the waveform unchanged.
- R6: After the lock is cleared, the staged period, duty and both polarities take effect together at the next counter wrap, and not before.
- R7: With the lock clear, a single write to period or duty first affects the waveform after the next counter wrap.
- R8: The counter register is read-only. Writes to offset 0x0 do not disturb the count.
- R9: Reads of period, duty and control return the last value written, including staged values under lock. Control bits 1, 2, 5 and 8 are stored and have no effect on `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte offset: 0x0 counter, 0x4 period, 0x8 duty, 0xC control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A wrong counter or a stale active value shows on `pwm_out` within one period, because every edge position of the waveform is compared against an arithmetic expectation for each period, duty and polarity combination in a small sweep. A transfer that happens too early shows one clock after the wrong edge, because the staged values differ visibly from the running ones. The counter register is also read on the bus, so a phase slip appears on the very next read, before it would reach the output.

// File: rtl/pwm_lockchan_pkg.sv
package pwm_lockchan_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_PER  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DUTY = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'hC;

  localparam int CB_EN   = 0;
  localparam int CB_DPOL = 3;
  localparam int CB_IPOL = 4;
  localparam int CB_LOCK = 6;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_lockchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  per_sh_o,
  output logic [CNT_W-1:0]  duty_sh_o,
  output logic              en_o,
  output logic              lock_o,
  output logic              dpol_o,
  output logic              ipol_o
);
  logic [BUS_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0] per_q, per_d, duty_q, duty_d;
  logic             per_wen, duty_wen, ctrl_wen;

  assign per_wen  = we_i && (addr_i == OFS_PER);
  assign duty_wen = we_i && (addr_i == OFS_DUTY);
  assign ctrl_wen = we_i && (addr_i == OFS_CTRL);

  always_comb begin
    per_d  = per_wen  ? wdata_i[CNT_W-1:0] : per_q;
    duty_d = duty_wen ? wdata_i[CNT_W-1:0] : duty_q;
    ctrl_d = ctrl_wen ? wdata_i            : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      per_q  <= per_d;
      duty_q <= duty_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_CNT:  rdata_o = BUS_W'(cnt_i);
      OFS_PER:  rdata_o = BUS_W'(per_q);
      OFS_DUTY: rdata_o = BUS_W'(duty_q);
      OFS_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = '0;
    endcase
  end

  assign per_sh_o  = per_q;
  assign duty_sh_o = duty_q;
  assign en_o      = ctrl_q[CB_EN];
  assign lock_o    = ctrl_q[CB_LOCK];
  assign dpol_o    = ctrl_q[CB_DPOL];
  assign ipol_o    = ctrl_q[CB_IPOL];
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             lock_i,
  input  logic             dpol_i,
  input  logic             ipol_i,
  input  logic [CNT_W-1:0] per_sh_i,
  input  logic [CNT_W-1:0] duty_sh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic [CNT_W-1:0] duty_act_o,
  output logic             dpol_act_o,
  output logic             ipol_act_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  logic             dpol_q, dpol_d, ipol_q, ipol_d;
  logic             at_end, boundary, load_en;

  // a period ends on the last count, on a zero period, or while stopped
  assign at_end   = (per_q == '0) || (cnt_q == per_q - ONE);
  assign boundary = !en_i || at_end;
  assign load_en  = boundary && !lock_i;

  always_comb begin
    cnt_d  = boundary ? '0 : cnt_q + ONE;
    per_d  = load_en ? per_sh_i  : per_q;
    duty_d = load_en ? duty_sh_i : duty_q;
    dpol_d = load_en ? dpol_i    : dpol_q;
    ipol_d = load_en ? ipol_i    : ipol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      dpol_q <= 1'b0;
      ipol_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      dpol_q <= dpol_d;
      ipol_q <= ipol_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign per_act_o  = per_q;
  assign duty_act_o = duty_q;
  assign dpol_act_o = dpol_q;
  assign ipol_act_o = ipol_q;
endmodule

// File: rtl/pwm_waveform.sv
module pwm_waveform #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             dpol_i,
  input  logic             ipol_i,
  output logic             pwm_o
);
  logic running, in_duty, out_d, out_q;

  assign running = en_i && (per_i != '0);
  assign in_duty = cnt_i < duty_i;

  always_comb begin
    if (!running)     out_d = ipol_i;
    else if (in_duty) out_d = dpol_i;
    else              out_d = !dpol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/pwm_lockchan.sv
module pwm_lockchan
  import pwm_lockchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt, per_sh, duty_sh, per_act, duty_act;
  logic             en, lock, dpol, ipol, dpol_act, ipol_act;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pwm_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we_i     (bus_we),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .cnt_i    (cnt),
    .rdata_o  (bus_rdata),
    .per_sh_o (per_sh),
    .duty_sh_o(duty_sh),
    .en_o     (en),
    .lock_o   (lock),
    .dpol_o   (dpol),
    .ipol_o   (ipol)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_i      (en),
    .lock_i    (lock),
    .dpol_i    (dpol),
    .ipol_i    (ipol),
    .per_sh_i  (per_sh),
    .duty_sh_i (duty_sh),
    .cnt_o     (cnt),
    .per_act_o (per_act),
    .duty_act_o(duty_act),
    .dpol_act_o(dpol_act),
    .ipol_act_o(ipol_act)
  );

  pwm_waveform #(.CNT_W(CNT_W)) u_wave (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en_i  (en),
    .cnt_i (cnt),
    .per_i (per_act),
    .duty_i(duty_act),
    .dpol_i(dpol_act),
    .ipol_i(ipol_act),
    .pwm_o (pwm_out)
  );
endmodule

// File: rtl/pwm_lockchan_chk.sv
module pwm_lockchan_chk
  import pwm_lockchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              en,
  input logic              lock,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per_act,
  input logic [CNT_W-1:0]  duty_act,
  input logic              dpol_act,
  input logic              ipol_act,
  input logic              pwm_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2: a stopped channel sits at zero count and idle level
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (cnt == '0) && (pwm_out == $past(ipol_act)));

  // R3: count stays inside the active period
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_act != '0) |-> (cnt < per_act));

  // R4: output level follows previous count against duty
  assert_out_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(per_act) != '0) |->
      (pwm_out == (($past(cnt) < $past(duty_act)) ? $past(dpol_act) : !$past(dpol_act))));

  // R5: locked configuration keeps every active field
  assert_hold_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> ($stable(per_act) && $stable(duty_act) &&
                     $stable(dpol_act) && $stable(ipol_act)));

  // R6 and R7: active values only move where a new period starts
  assert_move_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_act) || !$stable(duty_act) || !$stable(dpol_act)) |-> (cnt == '0));

  // R8: a counter write does not disturb the step
  assert_cnt_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_we && bus_addr == OFS_CNT && en && per_act != '0) &&
     ($past(cnt) != $past(per_act) - ONE)) |-> (cnt == $past(cnt) + ONE));
endmodule

bind pwm_lockchan pwm_lockchan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .en      (en),
  .lock    (lock),
  .cnt     (cnt),
  .per_act (per_act),
  .duty_act(duty_act),
  .dpol_act(dpol_act),
  .ipol_act(ipol_act),
  .pwm_out (pwm_out)
);

// File: tb/pwm_lockchan_tb.sv
module pwm_lockchan_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk;
  int n_bad;
  bit done;

  pwm_lockchan #(.CNT_W(16)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic lock_exp(input int e);
    int j;
    if (e <= 24) return ((e - 1) % 4) < 1;
    if (e <= 30) begin j = e - 25; return !((j % 6) < 3); end
    j = e - 31;
    return !((j % 6) < 5);
  endfunction

  initial begin
    logic [31:0] v;
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 out", {31'b0, pwm_out}, 32'h0);

    // R2 R3 R4: sweep period, duty and both polarities
    for (int p = 0; p <= 5; p++) begin
      for (int d = 0; d <= 6; d++) begin
        for (int pm = 0; pm < 4; pm++) begin
          logic dp, ip;
          logic [31:0] pol;
          dp  = pm[0];
          ip  = pm[1];
          pol = 32'h2 | (32'(dp) << 3) | (32'(ip) << 4);
          wr(4'h4, 32'(p));
          wr(4'h8, 32'(d));
          wr(4'hC, pol);
          step();
          step();
          check("R2 idle level", {31'b0, pwm_out}, {31'b0, ip});
          rd(4'h0, v);
          check("R2 count zero", v, 32'h0);
          wr(4'hC, pol | 32'h1);
          for (int e = 1; e <= 2 * p + 3; e++) begin
            logic ex;
            step();
            if (p == 0) ex = ip;
            else        ex = (((e - 1) % p) < d) ? dp : !dp;
            check("R4 waveform", {31'b0, pwm_out}, {31'b0, ex});
            rd(4'h0, v);
            check("R3 count", v, (p == 0) ? 32'h0 : 32'(e % p));
          end
        end
      end
    end

    // R5 R6 R7 R8 R9: locked staging, unlock transfer, single write
    wr(4'hC, 32'h0A);
    wr(4'h4, 32'd4);
    wr(4'h8, 32'd1);
    step();
    wr(4'hC, 32'h0B);
    for (int e = 1; e <= 45; e++) begin
      case (e)
        5:  begin bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'h4B;  end
        6:  begin bus_we = 1; bus_addr = 4'h4; bus_wdata = 32'd6;   end
        7:  begin bus_we = 1; bus_addr = 4'h8; bus_wdata = 32'd3;   end
        8:  begin bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'h53;  end
        21: begin bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'h133; end
        27: begin bus_we = 1; bus_addr = 4'h8; bus_wdata = 32'd5;   end
        33: begin bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'd7;   end
        default: ;
      endcase
      step();
      if (e <= 24)      check("R5 R6 locked then released waveform", {31'b0, pwm_out}, {31'b0, lock_exp(e)});
      else if (e <= 30) check("R6 new set together", {31'b0, pwm_out}, {31'b0, lock_exp(e)});
      else              check("R7 single write at wrap", {31'b0, pwm_out}, {31'b0, lock_exp(e)});
      if (e == 10) begin
        rd(4'h4, v); check("R9 staged period", v, 32'd6);
        rd(4'h8, v); check("R9 staged duty", v, 32'd3);
      end
      if (e == 12) begin rd(4'h0, v); check("R5 count keeps old period", v, 32'd0); end
      if (e == 20) begin rd(4'hC, v); check("R9 ctrl readback", v, 32'h53); end
      if (e == 22) begin rd(4'hC, v); check("R9 stored unused bits", v, 32'h133); end
      if (e == 34) begin rd(4'h0, v); check("R8 counter write ignored", v, 32'd4); end
    end

    // R2: stop with high idle level
    wr(4'hC, 32'h12);
    step();
    step();
    check("R2 idle high", {31'b0, pwm_out}, 32'h1);
    rd(4'h0, v);
    check("R2 stopped count", v, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule